// File: doc/BRIEF.md
# SMBus Byte-Access Memory Target

This block is an SMBus target that answers at one 7-bit bus address and serves two 128-byte memories through it. The first memory is a read-only information region whose contents are fixed by a parameter. The second is a writable scratch region that is cleared at reset. The host reaches one byte per packet. It uses a Write Byte packet to store a byte and a Read Byte packet to fetch one. The top bit of the command byte picks the region, and the low seven bits pick the byte inside it.

The SCL and SDA lines are brought into the system clock domain through two-flop synchronizers. START and STOP are found from SDA edges that occur while SCL is high. Bits are taken in on SCL rising edges. The target pulls SDA low for ACK and for zero data bits, and it changes its drive only while SCL is low.

The bus address is made of a parameter for the upper four bits, a fixed 0 below them, and two strap inputs as the lowest bits. A write into the information region completes with all its ACKs, but the stored contents do not change.

Top module: `smbt_target`

## Requirements
- R1: The target responds only to the address {ADDR_HI, 1'b0, strap[1:0]}. With the default ADDR_HI = 4'b1010 and strap = 2'b01, that address is 7'h51. A packet to any other address gets no ACK on any byte, stores nothing, and SDA stays released.
- R2: In a Write Byte packet (START, address with bit0 = 0, command, data, STOP), the target ACKs all three bytes. When command bit 7 is 1, the data byte is stored in the scratch region at index command[6:0].
- R3: When command bit 7 is 0, a Write Byte packet is still ACKed on all three bytes. The information region is unchanged, and so is every scratch byte.
- R4: In a Read Byte packet (START, address+write, command, repeated START, address with bit0 = 1, 8 data bits, host NACK, STOP), the target ACKs both address bytes and the command byte. It then drives the selected byte MSB first: scratch when command bit 7 is 1, information when it is 0.
- R5: With default parameters, information byte i holds (i*37 + 8'h5C) mod 256.
- R6: After reset, every scratch byte reads as 8'h00.
- R7: A STOP, or a START of any kind, that arrives before all 8 data bits of a Write Byte have been received cancels the write. The addressed byte keeps its old value.
- R8: An address byte with the read bit set that does not follow a command byte in the same transaction (placed before a repeated START) is NACKed.
- R9: The target changes SDA only while SCL is low. SDA is stable for the whole SCL high time while the target drives data.
- R10: While reset is asserted and right after it, SDA is released (sdaPullLow = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sensed level of the SCL line |
| sdaIn | input | 1 | Sensed level of the SDA line |
| strap | input | 2 | Low two bits of the target address |
| sdaPullLow | output | 1 | 1 pulls SDA low; 0 releases it (open drain) |

## Verification
The hardest situations to reach are the cancelled writes. These are a STOP or a repeated START that arrives partway through the data byte, after the address and command bytes have already been ACKed. A correct host driver never produces them. The bench therefore clocks out only a few data bits by hand and then issues the bus condition. After that it reads the addressed location back through a normal Read Byte. A second hard case is a read address byte with no command before it. The bench reaches it with a bare START followed by the address with the read bit set.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
  localparam int CMD_W = 8;
  localparam int IDX_W = 7;
  localparam int DEPTH = 1 << IDX_W;

  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftOut;
    logic latchCmd;
    logic writeMem;
  } smbtStrobe_t;

  function automatic logic [DEPTH*8-1:0] defaultInfo();
    logic [DEPTH*8-1:0] v;
    for (int i = 0; i < DEPTH; i++) v[i*8 +: 8] = 8'(i * 37 + 92);
    return v;
  endfunction
endpackage

// File: rtl/smbt_datapath.sv
module smbt_datapath import smbt_pkg::*; #(
  parameter logic [3:0]         ADDR_HI   = 4'b1010,
  parameter logic [DEPTH*8-1:0] INFO_INIT = defaultInfo()
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [1:0]  strap,
  input  smbtStrobe_t strobe,
  output logic        sclRise,
  output logic        sclFall,
  output logic        startDet,
  output logic        stopDet,
  output logic        addrHit,
  output logic        rwBit,
  output logic        txBit
);
  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclS, sdaS;
  logic [7:0] rxShift, txShift, cmdReg, readData;
  logic [IDX_W-1:0] cmdIdx;
  logic [7:0] scratchMem [DEPTH];

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  assign cmdIdx   = cmdReg[IDX_W-1:0];
  assign readData = cmdReg[CMD_W-1] ? scratchMem[cmdIdx] : INFO_INIT[{cmdIdx, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      cmdReg  <= '0;
    end else begin
      if (strobe.shiftIn)  rxShift <= {rxShift[6:0], sdaS};
      if (strobe.latchCmd) cmdReg  <= rxShift;
      if (strobe.loadTx)        txShift <= readData;
      else if (strobe.shiftOut) txShift <= {txShift[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) scratchMem[i] <= '0;
    end else if (strobe.writeMem && cmdReg[CMD_W-1]) begin
      scratchMem[cmdIdx] <= rxShift;
    end
  end

  assign addrHit = rxShift[7:1] == {ADDR_HI, 1'b0, strap};
  assign rwBit   = rxShift[0];
  assign txBit   = txShift[7];

  // R2
  scratch_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeMem && cmdReg[CMD_W-1] |=> scratchMem[$past(cmdIdx)] == $past(rxShift));

  // R3
  info_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeMem && !cmdReg[CMD_W-1] |=> scratchMem[$past(cmdIdx)] == $past(scratchMem[cmdIdx]));
endmodule

// File: rtl/smbt_control.sv
module smbt_control import smbt_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic        addrHit,
  input  logic        rwBit,
  input  logic        txBit,
  output smbtStrobe_t strobe,
  output logic        sdaPullLow
);
  typedef enum logic [3:0] {
    IDLE, RX_ADDR, ACK_ADDR, RX_CMD, ACK_CMD, RX_DATA, ACK_DATA, TX_DATA, HOST_ACK, WAIT_END
  } smbtState_t;

  smbtState_t state;
  logic [3:0] bitCnt;
  logic cmdValid, readPhase, byteDone, rxState;

  assign byteDone = sclFall && bitCnt == 4'd8;
  assign rxState  = state inside {RX_ADDR, RX_CMD, RX_DATA};

  always_comb begin
    strobe          = '0;
    strobe.shiftIn  = sclRise && rxState;
    strobe.loadTx   = sclFall && state == ACK_ADDR && readPhase;
    strobe.shiftOut = sclFall && state == TX_DATA && bitCnt != 4'd8;
    strobe.latchCmd = byteDone && state == RX_CMD;
    strobe.writeMem = byteDone && state == RX_DATA;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= IDLE;
      bitCnt    <= '0;
      cmdValid  <= 1'b0;
      readPhase <= 1'b0;
    end else if (startDet) begin
      state     <= RX_ADDR;
      bitCnt    <= '0;
      cmdValid  <= state == RX_DATA;
      readPhase <= 1'b0;
    end else if (stopDet) begin
      state     <= IDLE;
      bitCnt    <= '0;
      cmdValid  <= 1'b0;
      readPhase <= 1'b0;
    end else begin
      if (sclRise && (rxState || state == TX_DATA)) bitCnt <= bitCnt + 4'd1;
      case (state)
        RX_ADDR: if (byteDone) begin
          bitCnt <= '0;
          if (!addrHit)                 state <= WAIT_END;
          else if (!rwBit)              begin state <= ACK_ADDR; readPhase <= 1'b0; end
          else if (cmdValid)            begin state <= ACK_ADDR; readPhase <= 1'b1; end
          else                          state <= WAIT_END;
        end
        ACK_ADDR: if (sclFall) begin
          bitCnt <= '0;
          state  <= readPhase ? TX_DATA : RX_CMD;
        end
        RX_CMD:   if (byteDone) begin bitCnt <= '0; state <= ACK_CMD; end
        ACK_CMD:  if (sclFall)  begin bitCnt <= '0; state <= RX_DATA; end
        RX_DATA:  if (byteDone) begin bitCnt <= '0; state <= ACK_DATA; end
        ACK_DATA: if (sclFall)  state <= WAIT_END;
        TX_DATA:  if (byteDone) begin bitCnt <= '0; state <= HOST_ACK; end
        HOST_ACK: if (sclFall)  state <= WAIT_END;
        default: ;
      endcase
    end
  end

  assign sdaPullLow = (state inside {ACK_ADDR, ACK_CMD, ACK_DATA}) ||
                      (state == TX_DATA && !txBit);

  // R9
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> $past(sclFall || startDet || stopDet));

  // R7
  stop_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> state == IDLE && !sdaPullLow);

  // R1
  miss_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteDone && state == RX_ADDR && !addrHit |=> !sdaPullLow);

  // R8
  bare_read_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteDone && state == RX_ADDR && rwBit && !cmdValid |=> !sdaPullLow);

  // R4
  bit_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd8);
endmodule

// File: rtl/smbt_target.sv
module smbt_target import smbt_pkg::*; #(
  parameter logic [3:0]         ADDR_HI   = 4'b1010,
  parameter logic [DEPTH*8-1:0] INFO_INIT = defaultInfo()
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] strap,
  output logic       sdaPullLow
);
  smbtStrobe_t strobe;
  logic sclRise, sclFall, startDet, stopDet, addrHit, rwBit, txBit;

  smbt_datapath #(.ADDR_HI(ADDR_HI), .INFO_INIT(INFO_INIT)) u_datapath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strap(strap),
    .strobe(strobe), .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .addrHit(addrHit), .rwBit(rwBit), .txBit(txBit)
  );

  smbt_control u_control (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .addrHit(addrHit), .rwBit(rwBit),
    .txBit(txBit), .strobe(strobe), .sdaPullLow(sdaPullLow)
  );

  // R10
  reset_release_chk: assert property (@(posedge clk) !rstN |=> !sdaPullLow);
endmodule

// File: tb/smbt_target_bench.sv
module smbt_target_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic hostSda = 1'b1;
  logic [1:0] strap = 2'b01;
  logic sdaPullLow;
  logic sdaLine;
  int checks = 0;
  int errors = 0;
  int unstable = 0;
  logic [7:0] refScratch [128];

  always #4 clk = ~clk;
  assign sdaLine = hostSda & ~sdaPullLow;

  smbt_target u_smbt_target (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .strap(strap), .sdaPullLow(sdaPullLow)
  );

  function automatic logic [7:0] infoRef(input int i);
    return 8'((i * 37 + 92) % 256);
  endfunction

  function automatic logic [7:0] expectRead(input logic [7:0] cmd);
    return cmd[7] ? refScratch[cmd[6:0]] : infoRef(int'(cmd[6:0]));
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, output logic seen);
    logic s2;
    hostSda = b; waitQ();
    scl = 1'b1; waitQ();
    seen = sdaLine; waitQ();
    s2 = sdaLine;
    if (s2 != seen) unstable++;
    scl = 1'b0; waitQ();
  endtask

  task automatic startCond();
    hostSda = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    hostSda = 1'b0; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    hostSda = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    hostSda = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic nack);
    logic s;
    for (int i = 7; i >= 0; i--) sendBit(b[i], s);
    sendBit(1'b1, nack);
  endtask

  task automatic recvByte(output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin
      sendBit(1'b1, s);
      d = {d[6:0], s};
    end
    sendBit(1'b1, s);
  endtask

  task automatic writeTxn(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] dat,
                          output logic n1, output logic n2, output logic n3);
    startCond();
    sendByte({a, 1'b0}, n1);
    sendByte(cmd, n2);
    sendByte(dat, n3);
    stopCond();
  endtask

  task automatic readTxn(input logic [6:0] a, input logic [7:0] cmd,
                         output logic n1, output logic n2, output logic n3, output logic [7:0] d);
    startCond();
    sendByte({a, 1'b0}, n1);
    sendByte(cmd, n2);
    startCond();
    sendByte({a, 1'b1}, n3);
    recvByte(d);
    stopCond();
  endtask

  task automatic readCheck(input logic [6:0] a, input logic [7:0] cmd, input string req);
    logic n1, n2, n3;
    logic [7:0] d;
    readTxn(a, cmd, n1, n2, n3, d);
    check(!n1 && !n2 && !n3, {req, " read acks"}, {n1, n2, n3}, 0);
    check(d == expectRead(cmd), {req, " read data"}, d, expectRead(cmd));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic n1, n2, n3, s;
    logic [6:0] myAddr;
    logic [7:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) refScratch[i] = 8'h00;
    repeat (10) @(negedge clk);
    // R10 released during reset
    check(sdaPullLow == 1'b0, "R10", sdaPullLow, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(sdaPullLow == 1'b0, "R10", sdaPullLow, 0);
    myAddr = 7'h51;

    // R6 scratch cleared, R4 read path
    readCheck(myAddr, 8'h85, "R6");
    readCheck(myAddr, 8'hFF, "R6");
    // R5 info contents at both ends
    readCheck(myAddr, 8'h00, "R5");
    readCheck(myAddr, 8'h7F, "R5");
    readCheck(myAddr, 8'h2A, "R4");

    // R2 scratch write
    writeTxn(myAddr, 8'h85, 8'h3C, n1, n2, n3);
    check(!n1 && !n2 && !n3, "R2 acks", {n1, n2, n3}, 0);
    refScratch[5] = 8'h3C;
    readCheck(myAddr, 8'h85, "R2");

    // R3 write to information region is acked, no effect
    writeTxn(myAddr, 8'h05, 8'h77, n1, n2, n3);
    check(!n1 && !n2 && !n3, "R3 acks", {n1, n2, n3}, 0);
    readCheck(myAddr, 8'h05, "R3");
    readCheck(myAddr, 8'h85, "R3");

    // R1 wrong address
    writeTxn(7'h52, 8'h85, 8'h00, n1, n2, n3);
    check(n1 && n2 && n3, "R1 nack", {n1, n2, n3}, 7);
    readCheck(myAddr, 8'h85, "R1");

    // R8 read address with no command
    startCond();
    sendByte({myAddr, 1'b1}, n1);
    stopCond();
    check(n1 == 1'b1, "R8 nack", n1, 1);

    // R7 STOP after four data bits
    startCond();
    sendByte({myAddr, 1'b0}, n1);
    sendByte(8'h85, n2);
    for (int i = 0; i < 4; i++) sendBit(1'b0, s);
    stopCond();
    readCheck(myAddr, 8'h85, "R7");

    // R7 repeated START after three data bits, then a full write elsewhere
    startCond();
    sendByte({myAddr, 1'b0}, n1);
    sendByte(8'h86, n2);
    for (int i = 0; i < 3; i++) sendBit(1'b1, s);
    startCond();
    sendByte({myAddr, 1'b0}, n1);
    sendByte(8'h87, n2);
    sendByte(8'h11, n3);
    stopCond();
    check(!n1 && !n2 && !n3, "R7 acks", {n1, n2, n3}, 0);
    refScratch[7] = 8'h11;
    readCheck(myAddr, 8'h86, "R7");
    readCheck(myAddr, 8'h87, "R7");

    // R1 strap change moves the address
    strap = 2'b10;
    myAddr = 7'h52;
    writeTxn(myAddr, 8'h88, 8'h99, n1, n2, n3);
    check(!n1 && !n2 && !n3, "R1 strap acks", {n1, n2, n3}, 0);
    refScratch[8] = 8'h99;
    readCheck(myAddr, 8'h88, "R1");
    writeTxn(7'h51, 8'h88, 8'h00, n1, n2, n3);
    check(n1, "R1 old address", n1, 1);

    // random mix: R2 R3 R4 R1
    for (int k = 0; k < 40; k++) begin
      logic [7:0] cmd, dat;
      logic [6:0] a;
      int op;
      cmd = 8'($urandom);
      dat = 8'($urandom);
      op  = int'($urandom % 5);
      if (op == 0) begin
        a = myAddr ^ (7'd1 << ($urandom % 7));
        writeTxn(a, cmd, dat, n1, n2, n3);
        check(n1 && n2 && n3, "R1 random miss", {n1, n2, n3}, 7);
      end else if (op < 3) begin
        writeTxn(myAddr, cmd, dat, n1, n2, n3);
        check(!n1 && !n2 && !n3, cmd[7] ? "R2 random acks" : "R3 random acks", {n1, n2, n3}, 0);
        if (cmd[7]) refScratch[cmd[6:0]] = dat;
      end else begin
        readCheck(myAddr, cmd, "R4 random");
      end
    end

    // R9 target data held steady while SCL high
    check(unstable == 0, "R9", unstable, 0);
    d = 8'h00;
    check(sdaPullLow == 1'b0 && d == 8'h00, "R10 idle release", sdaPullLow, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule